// File: doc/BRIEF.md
# Daisy-Chain Converter Readback Master

This block drives a group of serial sampling converters that are wired in a daisy chain and share one three-wire port: a convert line, a serial clock and a single data return. When the system asks for a sample, the block raises the convert line and holds it through a conversion time set by a parameter. Throughout that time the serial clock stays low, which places the converters in chain mode. The block then issues one serial clock pulse per data bit for the whole chain and shifts in the stream that comes back from the converter nearest the host.

The collected stream is cut into one 16-bit word per converter. Each word has a fixed slot on the output bus: slot 0 holds the converter nearest the host, and higher slots hold converters further up the chain. A one-cycle valid strobe marks a finished frame. After the last bit the convert line goes low and stays low for a short quiet gap before the next frame can start.

The chain length, the serial clock half-period (counted in system clocks), the conversion wait and the capture edge are all parameters.

Top module: `chain_rdbk_host`

## Requirements
- R1: While rst_n is low, and after reset until a start is accepted, cnv_o, sck_o, busy_o and valid_o are all low.
- R2: A start_i seen high in idle raises cnv_o one clock later, with sck_o low. cnv_o is high for CONV_CYC+HALF_DIV system clocks before the first rising edge of sck_o.
- R3: A frame has exactly N_DEV×16 sck_o pulses. Each high phase lasts HALF_DIV clocks. sck_o is high only while cnv_o is high, and cnv_o stays high until the clock edge of the last falling sck_o edge.
- R4: Bits arrive MSB first, and the nearest converter's word arrives first. Slot k is words_o[16k+15:16k]. It holds received bits 16k to 16k+15, and the earliest of these goes to bit 16k+15.
- R5: With CAPTURE_RISE=0, each bit is taken at the system clock edge where sck_o goes from high to low. The value taken is the one on the data line during the high phase just ending. The first bit must be on the line from the end of conversion.
- R6: With CAPTURE_RISE=1, each bit is taken at the edge where sck_o goes from low to high, so the first bit is taken before the first falling edge.
- R7: busy_o goes high the clock after a start is accepted. A start_i pulse while busy_o is high is ignored: no extra frame and no extra sck_o pulses.
- R8: valid_o is high for exactly one clock, in the cycle after the last falling sck_o edge, and cnv_o is low in that cycle. words_o then holds the completed frame.
- R9: busy_o stays high for 2×HALF_DIV clocks starting with the valid_o cycle. With start_i held high, cnv_o is low for 2×HALF_DIV+1 clocks between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request one conversion and readback frame |
| chain_dat_i | input | 1 | Serial data from the converter nearest the host |
| cnv_o | output | 1 | Convert line, high through conversion and readback |
| sck_o | output | 1 | Serial clock to the chain |
| busy_o | output | 1 | Frame or quiet gap in progress |
| valid_o | output | 1 | One-cycle strobe: words_o holds a new frame |
| words_o | output | N_DEV×16 (32) | Captured words, slot 0 = nearest converter |

## Verification
A table of 32-bit chain streams is played through two instances, one per capture edge. The streams are all zeros, all ones, alternating halves, single set bits at both ends of the stream, and mixed values. They show whether each bit lands in the right slot and bit position, and whether the two converter words are swapped or bit-reversed. The bench's converter model drives the true bit only during the phase the chosen capture edge samples and drives the inverted bit in the other phase, so sampling on the wrong edge corrupts the words. Directed runs measure the conversion wait, the pulse count and the high-phase width, a start pulse during a frame, the busy tail after valid, and the convert-low gap when start is held.

// File: rtl/chain_rdbk_pkg.sv
package chain_rdbk_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_GAP   = 2'd3
  } rd_state_t;

endpackage

// File: rtl/chain_tmr.sv
module chain_tmr #(
  parameter int TW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  output logic          zero_o
);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    if (load_i) cnt_d = val_i;
    else        cnt_d = cnt_q - TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/chain_sck_gen.sv
module chain_sck_gen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic sck_o,
  output logic rise_o,
  output logic fall_o
);

  localparam int HW = $clog2(HALF_DIV + 1);

  logic [HW-1:0] hc_q, hc_d;
  logic          sck_q, sck_d;
  logic          wrap;

  assign wrap = (hc_q == HW'(HALF_DIV - 1));

  always_comb begin
    if (!en_i) begin
      hc_d  = '0;
      sck_d = 1'b0;
    end else if (wrap) begin
      hc_d  = '0;
      sck_d = ~sck_q;
    end else begin
      hc_d  = hc_q + HW'(1);
      sck_d = sck_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc_q  <= '0;
      sck_q <= 1'b0;
    end else begin
      hc_q  <= hc_d;
      sck_q <= sck_d;
    end
  end

  assign sck_o  = sck_q;
  assign rise_o = en_i & wrap & ~sck_q;
  assign fall_o = en_i & wrap &  sck_q;

endmodule

// File: rtl/chain_deser.sv
module chain_deser #(
  parameter int N_DEV        = 2,
  parameter int WORD_W       = 16,
  parameter bit CAPTURE_RISE = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rise_i,
  input  logic                    fall_i,
  input  logic                    dat_i,
  output logic [N_DEV*WORD_W-1:0] words_o
);

  localparam int TOTAL = N_DEV * WORD_W;

  logic             smp;
  logic [TOTAL-1:0] sr_q, sr_d;

  assign smp  = CAPTURE_RISE ? rise_i : fall_i;
  assign sr_d = {sr_q[TOTAL-2:0], dat_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sr_q <= '0;
    else if (smp) sr_q <= sr_d;
  end

  // earliest word received goes to slot 0
  for (genvar k = 0; k < N_DEV; k++) begin : g_slot
    assign words_o[k*WORD_W +: WORD_W] = sr_q[TOTAL-1-k*WORD_W -: WORD_W];
  end

endmodule

// File: rtl/chain_rdbk_host.sv
module chain_rdbk_host
  import chain_rdbk_pkg::*;
#(
  parameter int N_DEV        = 2,
  parameter int WORD_W       = 16,
  parameter int HALF_DIV     = 2,
  parameter int CONV_CYC     = 24,
  parameter bit CAPTURE_RISE = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic                    chain_dat_i,
  output logic                    cnv_o,
  output logic                    sck_o,
  output logic                    busy_o,
  output logic                    valid_o,
  output logic [N_DEV*WORD_W-1:0] words_o
);

  localparam int TOTAL   = N_DEV * WORD_W;
  localparam int PCW     = $clog2(TOTAL + 1);
  localparam int GAP_CYC = 2 * HALF_DIV;
  localparam int TMAX    = (CONV_CYC > GAP_CYC) ? CONV_CYC : GAP_CYC;
  localparam int TW      = $clog2(TMAX + 1);

  rd_state_t      state_q, state_d;
  logic [PCW-1:0] pcnt_q, pcnt_d;
  logic           cnv_q, cnv_d;
  logic           valid_q, valid_d;
  logic           tmr_load, tmr_zero;
  logic [TW-1:0]  tmr_val;
  logic           sck_en, sck_rise, sck_fall, last_fall;

  assign sck_en    = (state_q == ST_SHIFT);
  assign last_fall = sck_fall && (pcnt_q == PCW'(TOTAL - 1));

  chain_tmr #(.TW(TW)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  chain_sck_gen #(.HALF_DIV(HALF_DIV)) u_sck (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (sck_en),
    .sck_o  (sck_o),
    .rise_o (sck_rise),
    .fall_o (sck_fall)
  );

  chain_deser #(
    .N_DEV        (N_DEV),
    .WORD_W       (WORD_W),
    .CAPTURE_RISE (CAPTURE_RISE)
  ) u_deser (
    .clk     (clk),
    .rst_n   (rst_n),
    .rise_i  (sck_rise),
    .fall_i  (sck_fall),
    .dat_i   (chain_dat_i),
    .words_o (words_o)
  );

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d  = ST_CONV;
        tmr_load = 1'b1;
        tmr_val  = TW'(CONV_CYC - 1);
      end
      ST_CONV: if (tmr_zero) state_d = ST_SHIFT;
      ST_SHIFT: if (last_fall) begin
        state_d  = ST_GAP;
        tmr_load = 1'b1;
        tmr_val  = TW'(GAP_CYC - 1);
      end
      ST_GAP: if (tmr_zero) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    if (!sck_en)       pcnt_d = '0;
    else if (sck_fall) pcnt_d = pcnt_q + PCW'(1);
    else               pcnt_d = pcnt_q;
    cnv_d   = (state_d == ST_CONV) || (state_d == ST_SHIFT);
    valid_d = last_fall;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pcnt_q  <= '0;
      cnv_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      pcnt_q  <= pcnt_d;
      cnv_q   <= cnv_d;
      valid_q <= valid_d;
    end
  end

  assign cnv_o   = cnv_q;
  assign valid_o = valid_q;
  assign busy_o  = (state_q != ST_IDLE);

endmodule

// File: rtl/chain_rdbk_host_chk.sv
module chain_rdbk_host_chk #(
  parameter int N_DEV  = 2,
  parameter int WORD_W = 16
) (
  input logic clk,
  input logic rst_n,
  input logic cnv_o,
  input logic sck_o,
  input logic busy_o,
  input logic valid_o
);

  localparam int TOTAL = N_DEV * WORD_W;
  localparam int CW    = $clog2(TOTAL + 2);

  logic          sck_prev_q;
  logic [CW-1:0] rises_q;
  logic          sck_rise;

  assign sck_rise = sck_o & ~sck_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_prev_q <= 1'b0;
      rises_q    <= '0;
    end else begin
      sck_prev_q <= sck_o;
      if (!cnv_o)        rises_q <= '0;
      else if (sck_rise) rises_q <= rises_q + CW'(1);
    end
  end

  // R2
  sck_low_at_cnv_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnv_o) |-> !sck_o);

  // R3
  sck_in_cnv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sck_o |-> cnv_o);

  // R3
  pulse_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sck_rise |-> (rises_q < CW'(TOTAL)));

  // R3
  cnv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cnv_o) |-> (rises_q == CW'(TOTAL)));

  // R7
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnv_o) |-> !$past(busy_o));

  // R7
  cnv_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_o |-> busy_o);

  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  // R8
  valid_outside_cnv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (!cnv_o && busy_o));

endmodule

bind chain_rdbk_host chain_rdbk_host_chk #(.N_DEV(N_DEV), .WORD_W(WORD_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cnv_o   (cnv_o),
  .sck_o   (sck_o),
  .busy_o  (busy_o),
  .valid_o (valid_o)
);

// File: tb/tb_chain_rdbk_host.sv
`timescale 1ns/100ps
module tb_chain_rdbk_host;

  localparam int N     = 2;
  localparam int H     = 2;
  localparam int C     = 24;
  localparam int TOTAL = N * 16;
  localparam int NVEC  = 6;

  // {stream as received, expected words_o}
  localparam logic [63:0] VEC [NVEC] = '{
    {32'h0000_0000, 32'h0000_0000},
    {32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {32'hA5C3_1E7B, 32'h1E7B_A5C3},
    {32'h8000_0001, 32'h0001_8000},
    {32'h5555_AAAA, 32'hAAAA_5555},
    {32'h1234_FEDC, 32'hFEDC_1234}
  };

  logic clk, rst_n, start;
  logic cnv_f, sck_f, busy_f, valid_f, dat_f;
  logic cnv_r, sck_r, busy_r, valid_r, dat_r;
  logic [TOTAL-1:0] words_f, words_r;
  logic [TOTAL-1:0] frame_data, mdl_f, mdl_r;
  logic sck_f_d, sck_r_d;
  int n_chk, n_fail;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  chain_rdbk_host #(.N_DEV(N), .HALF_DIV(H), .CONV_CYC(C), .CAPTURE_RISE(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .chain_dat_i(dat_f),
    .cnv_o(cnv_f), .sck_o(sck_f), .busy_o(busy_f), .valid_o(valid_f), .words_o(words_f));

  chain_rdbk_host #(.N_DEV(N), .HALF_DIV(H), .CONV_CYC(C), .CAPTURE_RISE(1'b1)) dut_r (
    .clk(clk), .rst_n(rst_n), .start_i(start), .chain_dat_i(dat_r),
    .cnv_o(cnv_r), .sck_o(sck_r), .busy_o(busy_r), .valid_o(valid_r), .words_o(words_r));

  // chain model: shifts after each falling sck; true bit only in the sampled phase
  always @(sck_f) sck_f_d <= #1 sck_f;
  always @(sck_r) sck_r_d <= #1 sck_r;
  assign dat_f = sck_f_d ? mdl_f[TOTAL-1] : ~mdl_f[TOTAL-1];
  assign dat_r = sck_r_d ? ~mdl_r[TOTAL-1] : mdl_r[TOTAL-1];

  initial begin
    mdl_f = '0;
    forever begin
      @(posedge cnv_f);
      mdl_f = frame_data;
      repeat (TOTAL) begin
        @(negedge sck_f);
        #1 mdl_f = mdl_f << 1;
      end
    end
  end

  initial begin
    mdl_r = '0;
    forever begin
      @(posedge cnv_r);
      mdl_r = frame_data;
      repeat (TOTAL) begin
        @(negedge sck_r);
        #1 mdl_r = mdl_r << 1;
      end
    end
  end

  // port monitor on the falling-capture instance
  int rise_cnt, pre_cnt, hi_run, half_bad, lo_run, last_lo, frame_cnt;
  bit seen, prev_sck, prev_cnv;
  initial begin
    rise_cnt = 0; pre_cnt = 0; hi_run = 0; half_bad = 0; lo_run = 0;
    last_lo = 0; frame_cnt = 0; seen = 0; prev_sck = 0; prev_cnv = 0;
  end
  always @(negedge clk) if (rst_n) begin
    if (cnv_f && !prev_cnv) begin
      last_lo = lo_run; rise_cnt = 0; seen = 0; pre_cnt = 1; frame_cnt++;
    end else if (cnv_f && !seen) begin
      if (sck_f) seen = 1; else pre_cnt++;
    end
    if (sck_f && !prev_sck) rise_cnt++;
    if (sck_f) hi_run++;
    else begin
      if (prev_sck && hi_run != H) half_bad++;
      hi_run = 0;
    end
    if (!cnv_f) lo_run++; else lo_run = 0;
    prev_sck = sck_f;
    prev_cnv = cnv_f;
  end

  task automatic tick;
    @(negedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_valid;
    while (!valid_f) tick;
  endtask

  task automatic wait_idle;
    while (busy_f || busy_r) tick;
  endtask

  task automatic run_frame(input logic [TOTAL-1:0] d, input logic [TOTAL-1:0] exp);
    frame_data = d;
    start = 1'b1; tick; start = 1'b0;
    check(busy_f && cnv_f && !sck_f, "R7 busy/cnv after start", {busy_f, cnv_f, sck_f}, 3'b110);
    wait_valid;
    check(words_f == exp, "R4 R5 falling capture words", words_f, exp);
    check(valid_r && words_r == exp, "R6 rising capture words", words_r, exp);
    check(rise_cnt == TOTAL, "R3 pulse count", rise_cnt, TOTAL);
    check(pre_cnt == C + H, "R2 conversion wait", pre_cnt, C + H);
    check(half_bad == 0, "R3 high phase width", half_bad, 0);
    check(!cnv_f, "R8 cnv low at valid", cnv_f, 0);
    tick;
    check(!valid_f, "R8 valid single cycle", valid_f, 0);
    wait_idle;
  endtask

  task automatic run_tests;
    int bcnt;
    int f0;
    // R1 reset state
    start = 1'b0; frame_data = '0; rst_n = 1'b0;
    repeat (3) tick;
    check({cnv_f, sck_f, busy_f, valid_f} == 4'b0, "R1 outputs in reset",
          {cnv_f, sck_f, busy_f, valid_f}, 0);
    rst_n = 1'b1;
    repeat (4) tick;
    check({cnv_f, sck_f, busy_f, valid_f} == 4'b0, "R1 outputs after reset",
          {cnv_f, sck_f, busy_f, valid_f}, 0);

    for (int i = 0; i < NVEC; i++) run_frame(VEC[i][63:32], VEC[i][31:0]);

    // R7: start pulsed mid-frame is ignored
    f0 = frame_cnt;
    frame_data = 32'hC0DE_7E57;
    start = 1'b1; tick; start = 1'b0;
    repeat (60) tick;
    start = 1'b1; tick; start = 1'b0;
    wait_valid;
    check(rise_cnt == TOTAL, "R7 pulses unchanged by busy start", rise_cnt, TOTAL);
    check(words_f == 32'h7E57_C0DE, "R7 words unchanged by busy start", words_f, 32'h7E57_C0DE);
    // R9: busy tail from valid inclusive
    bcnt = 0;
    while (busy_f) begin bcnt++; tick; end
    check(bcnt == 2 * H, "R9 busy tail after valid", bcnt, 2 * H);
    repeat (40) tick;
    check(frame_cnt == f0 + 1 && !cnv_f, "R7 no extra frame", frame_cnt - f0, 1);

    // R9: start held high gives back-to-back frames with minimum gap
    frame_data = 32'h0F0F_8001;
    start = 1'b1;
    wait_valid;
    f0 = frame_cnt;
    while (frame_cnt == f0) tick;
    start = 1'b0;
    check(last_lo == 2 * H + 1, "R9 cnv low gap", last_lo, 2 * H + 1);
    wait_valid;
    check(words_f == 32'h8001_0F0F, "R4 second back-to-back frame", words_f, 32'h8001_0F0F);
    wait_idle;
  endtask

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; start = 1'b0; frame_data = '0;
    fork
      run_tests;
      begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=expired expected=done");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule